// File: doc/BRIEF.md
# Audio FIFO Watermark and DMA Request Generator

This block sits beside the two 8-entry sample FIFOs of an audio serial port and turns their fill levels into service signals. It compares the transmit level against a low watermark and the receive level against a high watermark. It keeps sticky error flags for transmit underflow and receive overflow. It combines the four flags under individual enables into one interrupt line. It also raises a DMA request for each direction, either whenever a single word can move or only when four words can move at once.

The FIFO storage and the serializers are outside the block. They supply the current levels, one-cycle error event pulses and flush pulses. Software-side logic supplies the watermark values, the enables and the one-cycle clear pulses. While the core is halted for debug, each direction's DMA request can be held off through that direction's halt enable. All outputs are registered once from the inputs. The one exception is the flush gating, which acts on the DMA request lines in the same cycle.

Top module: `audio_fifo_dma_req`

## Requirements
- R1: One clock after inputs are sampled, `tx_low_flag` is 1 exactly when `tx_level` <= `tx_wmark`; it is not sticky.
- R2: One clock after inputs are sampled, `rx_high_flag` is 1 exactly when `rx_level` >= `rx_wmark`; it is not sticky.
- R3: A pulse on `tx_underflow_evt` sets `tx_unf_flag` on the next clock. The flag then holds until a `tx_unf_clr` pulse clears it. When set and clear come in the same cycle, set wins.
- R4: `rx_ovf_flag` behaves as R3, using `rx_overflow_evt` and `rx_ovf_clr`.
- R5: `irq` is registered and equals the OR of the next flag values ANDed with `irq_en`. The enable bits are: bit 0 underflow, bit 1 overflow, bit 2 transmit low watermark, bit 3 receive high watermark.
- R6: With `tx_dma_en`=1 and `tx_burst`=0, `tx_dma_req` is 1 one clock later exactly when `tx_level` < 8.
- R7: With `tx_dma_en`=1 and `tx_burst`=1, `tx_dma_req` is 1 one clock later exactly when `tx_level` < 5.
- R8: With `rx_dma_en`=1 and `rx_burst`=0, `rx_dma_req` is 1 one clock later exactly when `rx_level` >= 1.
- R9: With `rx_dma_en`=1 and `rx_burst`=1, `rx_dma_req` is 1 one clock later exactly when `rx_level` > 3.
- R10: When a direction's DMA enable is 0, that direction's request is 0 one clock later, whatever the level.
- R11: When `core_debug`=1 and a direction's debug-halt enable is 1, that direction's request is 0 one clock later. The other direction is unaffected.
- R12: A flush pulse forces that direction's request to 0 in the same cycle and also in the following cycle.
- R13: While `rst_n` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 4 | Transmit FIFO fill level (0..8) |
| rx_level | input | 4 | Receive FIFO fill level (0..8) |
| tx_wmark | input | 4 | Transmit low watermark |
| rx_wmark | input | 4 | Receive high watermark |
| tx_underflow_evt | input | 1 | Transmit underflow event pulse |
| rx_overflow_evt | input | 1 | Receive overflow event pulse |
| tx_unf_clr | input | 1 | Write-one-to-clear pulse for the underflow flag |
| rx_ovf_clr | input | 1 | Write-one-to-clear pulse for the overflow flag |
| irq_en | input | 4 | Interrupt enables (bit order as in R5) |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| tx_burst | input | 1 | Transmit four-word burst mode |
| rx_burst | input | 1 | Receive four-word burst mode |
| tx_dbg_halt_en | input | 1 | Hold off transmit requests during core debug |
| rx_dbg_halt_en | input | 1 | Hold off receive requests during core debug |
| core_debug | input | 1 | Core is in debug mode |
| tx_flush | input | 1 | Transmit FIFO flush pulse |
| rx_flush | input | 1 | Receive FIFO flush pulse |
| tx_unf_flag | output | 1 | Sticky transmit underflow flag |
| rx_ovf_flag | output | 1 | Sticky receive overflow flag |
| tx_low_flag | output | 1 | Transmit level at or below watermark |
| rx_high_flag | output | 1 | Receive level at or above watermark |
| irq | output | 1 | Combined interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The request logic is driven at the levels on each side of every threshold: 7 and 8 for transmit single-word mode, 4 and 5 for transmit burst mode, 0 and 1 for receive single-word mode, and 3 and 4 for receive burst mode. An off-by-one or a swapped comparison therefore shows up as a wrong request. The watermark flags are tested both at equality and one step past it, which separates at-or-below from strictly-below. The interrupt is tried with each source enabled alone, which exposes a mis-ordered enable bit. The sticky flags are tested with set and clear in the same cycle. Debug gating is applied to one direction while the other stays active.

// File: rtl/afd_pkg.sv
package afd_pkg;
    typedef struct packed {
        logic tx_unf;
        logic rx_ovf;
        logic tx_low;
        logic rx_high;
        logic irq;
        logic tx_req;
        logic rx_req;
    } afd_state_t;
endpackage

// File: rtl/afd_sticky_flag.sv
module afd_sticky_flag (
    input  logic set_evt,
    input  logic clr_evt,
    input  logic cur,
    output logic nxt
);
    // Set has priority over a simultaneous clear.
    assign nxt = set_evt | (cur & ~clr_evt);
endmodule

// File: rtl/afd_wmark_cmp.sv
module afd_wmark_cmp #(
    parameter int LVL_W    = 4,
    parameter bit AT_BELOW = 1'b1
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] mark,
    output logic             hit
);
    generate
        if (AT_BELOW) begin : g_low
            assign hit = (level <= mark);
        end else begin : g_high
            assign hit = (level >= mark);
        end
    endgenerate
endmodule

// File: rtl/afd_dma_gen.sv
module afd_dma_gen #(
    parameter int LVL_W = 4,
    parameter int DEPTH = 8,
    parameter int BURST = 4,
    parameter bit IS_TX = 1'b1
) (
    input  logic [LVL_W-1:0] level,
    input  logic             dma_en,
    input  logic             burst,
    input  logic             halt_en,
    input  logic             core_debug,
    input  logic             flush,
    output logic             req_nxt
);
    localparam logic [LVL_W-1:0] FULL_LVL  = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] TX_ROOM   = LVL_W'(DEPTH - BURST + 1);
    localparam logic [LVL_W-1:0] RX_AVAIL  = LVL_W'(BURST - 1);

    logic single_ok;
    logic burst_ok;

    generate
        if (IS_TX) begin : g_tx
            assign single_ok = (level < FULL_LVL);
            assign burst_ok  = (level < TX_ROOM);
        end else begin : g_rx
            assign single_ok = (level != '0);
            assign burst_ok  = (level > RX_AVAIL);
        end
    endgenerate

    assign req_nxt = dma_en & (burst ? burst_ok : single_ok)
                   & ~(halt_en & core_debug) & ~flush;
endmodule

// File: rtl/audio_fifo_dma_req.sv
module audio_fifo_dma_req #(
    parameter int LVL_W = 4,
    parameter int DEPTH = 8,
    parameter int BURST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_wmark,
    input  logic [LVL_W-1:0] rx_wmark,
    input  logic             tx_underflow_evt,
    input  logic             rx_overflow_evt,
    input  logic             tx_unf_clr,
    input  logic             rx_ovf_clr,
    input  logic [3:0]       irq_en,
    input  logic             tx_dma_en,
    input  logic             rx_dma_en,
    input  logic             tx_burst,
    input  logic             rx_burst,
    input  logic             tx_dbg_halt_en,
    input  logic             rx_dbg_halt_en,
    input  logic             core_debug,
    input  logic             tx_flush,
    input  logic             rx_flush,
    output logic             tx_unf_flag,
    output logic             rx_ovf_flag,
    output logic             tx_low_flag,
    output logic             rx_high_flag,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req
);
    import afd_pkg::*;

    afd_state_t st_d, st_q;
    logic unf_nxt, ovf_nxt, low_hit, high_hit, tx_req_nxt, rx_req_nxt;

    afd_sticky_flag u_unf (
        .set_evt(tx_underflow_evt), .clr_evt(tx_unf_clr),
        .cur(st_q.tx_unf), .nxt(unf_nxt)
    );
    afd_sticky_flag u_ovf (
        .set_evt(rx_overflow_evt), .clr_evt(rx_ovf_clr),
        .cur(st_q.rx_ovf), .nxt(ovf_nxt)
    );

    afd_wmark_cmp #(.LVL_W(LVL_W), .AT_BELOW(1'b1)) u_low (
        .level(tx_level), .mark(tx_wmark), .hit(low_hit)
    );
    afd_wmark_cmp #(.LVL_W(LVL_W), .AT_BELOW(1'b0)) u_high (
        .level(rx_level), .mark(rx_wmark), .hit(high_hit)
    );

    afd_dma_gen #(.LVL_W(LVL_W), .DEPTH(DEPTH), .BURST(BURST), .IS_TX(1'b1)) u_tx_dma (
        .level(tx_level), .dma_en(tx_dma_en), .burst(tx_burst),
        .halt_en(tx_dbg_halt_en), .core_debug(core_debug),
        .flush(tx_flush), .req_nxt(tx_req_nxt)
    );
    afd_dma_gen #(.LVL_W(LVL_W), .DEPTH(DEPTH), .BURST(BURST), .IS_TX(1'b0)) u_rx_dma (
        .level(rx_level), .dma_en(rx_dma_en), .burst(rx_burst),
        .halt_en(rx_dbg_halt_en), .core_debug(core_debug),
        .flush(rx_flush), .req_nxt(rx_req_nxt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.tx_unf  = unf_nxt;
        st_d.rx_ovf  = ovf_nxt;
        st_d.tx_low  = low_hit;
        st_d.rx_high = high_hit;
        st_d.irq     = |({high_hit, low_hit, ovf_nxt, unf_nxt} & irq_en);
        st_d.tx_req  = tx_req_nxt;
        st_d.rx_req  = rx_req_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_unf_flag  = st_q.tx_unf;
    assign rx_ovf_flag  = st_q.rx_ovf;
    assign tx_low_flag  = st_q.tx_low;
    assign rx_high_flag = st_q.rx_high;
    assign irq          = st_q.irq;
    // Flush takes effect on the request lines in its own cycle.
    assign tx_dma_req   = st_q.tx_req & ~tx_flush;
    assign rx_dma_req   = st_q.rx_req & ~rx_flush;
endmodule

// File: rtl/afd_checker.sv
module afd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] tx_level,
    input logic [3:0] tx_wmark,
    input logic [3:0] rx_level,
    input logic [3:0] rx_wmark,
    input logic       tx_underflow_evt,
    input logic       tx_unf_clr,
    input logic [3:0] irq_en,
    input logic       rx_dma_en,
    input logic       rx_burst,
    input logic       tx_dbg_halt_en,
    input logic       core_debug,
    input logic       tx_flush,
    input logic       rx_flush,
    input logic       tx_unf_flag,
    input logic       tx_low_flag,
    input logic       rx_high_flag,
    input logic       irq,
    input logic       tx_dma_req,
    input logic       rx_dma_req
);
    AST_TX_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= tx_wmark) |=> tx_low_flag); // R1
    AST_RX_HIGH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level < rx_wmark) |=> !rx_high_flag); // R2
    AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underflow_evt |=> tx_unf_flag); // R3
    AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_unf_flag && !tx_unf_clr) |=> tx_unf_flag); // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 4'b0000) |=> !irq); // R5
    AST_RX_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dma_en && rx_burst && rx_level < 4'd4) |=> !rx_dma_req); // R9
    AST_TX_DBG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_debug && tx_dbg_halt_en) |=> !tx_dma_req); // R11
    AST_TX_FLUSH_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> !tx_dma_req); // R12
    AST_RX_FLUSH_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |-> !rx_dma_req); // R12
endmodule

bind audio_fifo_dma_req afd_checker u_afd_checker (.*);

// File: tb/tb_audio_fifo_dma_req.sv
`timescale 1ns/1ps
module tb_audio_fifo_dma_req;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tx_level = '0, rx_level = '0, tx_wmark = '0, rx_wmark = '0;
    logic       tx_underflow_evt = 0, rx_overflow_evt = 0, tx_unf_clr = 0, rx_ovf_clr = 0;
    logic [3:0] irq_en = '0;
    logic       tx_dma_en = 0, rx_dma_en = 0, tx_burst = 0, rx_burst = 0;
    logic       tx_dbg_halt_en = 0, rx_dbg_halt_en = 0, core_debug = 0;
    logic       tx_flush = 0, rx_flush = 0;
    logic       tx_unf_flag, rx_ovf_flag, tx_low_flag, rx_high_flag, irq, tx_dma_req, rx_dma_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    audio_fifo_dma_req dut (.*);

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(tx_unf_flag | rx_ovf_flag | tx_low_flag | rx_high_flag, 1'b0, "R13 flags in reset");
        check(irq | tx_dma_req | rx_dma_req, 1'b0, "R13 irq/req in reset");
    endtask

    task automatic t_wmark();
        tx_wmark = 4'd3; tx_level = 4'd3; tick();
        check(tx_low_flag, 1'b1, "R1 level equals watermark");
        tx_level = 4'd4; tick();
        check(tx_low_flag, 1'b0, "R1 level above watermark");
        rx_wmark = 4'd6; rx_level = 4'd5; tick();
        check(rx_high_flag, 1'b0, "R2 level below watermark");
        rx_level = 4'd6; tick();
        check(rx_high_flag, 1'b1, "R2 level equals watermark");
        rx_level = 4'd2; tick();
        check(rx_high_flag, 1'b0, "R2 not sticky");
    endtask

    task automatic t_sticky();
        tx_underflow_evt = 1; tick(); tx_underflow_evt = 0;
        check(tx_unf_flag, 1'b1, "R3 set by event");
        tick();
        check(tx_unf_flag, 1'b1, "R3 holds");
        tx_unf_clr = 1; tick(); tx_unf_clr = 0;
        check(tx_unf_flag, 1'b0, "R3 cleared");
        tx_underflow_evt = 1; tx_unf_clr = 1; tick();
        tx_underflow_evt = 0; tx_unf_clr = 0;
        check(tx_unf_flag, 1'b1, "R3 set wins over clear");
        tx_unf_clr = 1; tick(); tx_unf_clr = 0;
        rx_overflow_evt = 1; tick(); rx_overflow_evt = 0; tick();
        check(rx_ovf_flag, 1'b1, "R4 set and hold");
        rx_ovf_clr = 1; tick(); rx_ovf_clr = 0;
        check(rx_ovf_flag, 1'b0, "R4 cleared");
    endtask

    task automatic t_irq();
        tx_level = 4'd5; tx_wmark = 4'd0; rx_level = 4'd0; rx_wmark = 4'd1;
        irq_en = 4'hF; tick();
        check(irq, 1'b0, "R5 no flag set");
        irq_en = 4'b0001; rx_overflow_evt = 1; tick(); rx_overflow_evt = 0;
        check(irq, 1'b0, "R5 overflow masked by bit0 only");
        irq_en = 4'b0010; tick();
        check(irq, 1'b1, "R5 overflow enabled by bit1");
        rx_ovf_clr = 1; irq_en = 4'b0100; tx_level = 4'd0; tick(); rx_ovf_clr = 0;
        check(irq, 1'b1, "R5 tx low via bit2");
        irq_en = 4'b1000; tick();
        check(irq, 1'b0, "R5 rx high not set");
        rx_level = 4'd1; tick();
        check(irq, 1'b1, "R5 rx high via bit3");
        irq_en = '0; tick();
        check(irq, 1'b0, "R5 all masked");
    endtask

    task automatic t_tx_dma();
        tx_dma_en = 1; tx_burst = 0; tx_level = 4'd7; tick();
        check(tx_dma_req, 1'b1, "R6 one free entry");
        tx_level = 4'd8; tick();
        check(tx_dma_req, 1'b0, "R6 full");
        tx_burst = 1; tx_level = 4'd4; tick();
        check(tx_dma_req, 1'b1, "R7 level 4");
        tx_level = 4'd5; tick();
        check(tx_dma_req, 1'b0, "R7 level 5");
        tx_dma_en = 0; tx_level = 4'd0; tick();
        check(tx_dma_req, 1'b0, "R10 tx disabled");
    endtask

    task automatic t_rx_dma();
        rx_dma_en = 1; rx_burst = 0; rx_level = 4'd0; tick();
        check(rx_dma_req, 1'b0, "R8 empty");
        rx_level = 4'd1; tick();
        check(rx_dma_req, 1'b1, "R8 one word");
        rx_burst = 1; rx_level = 4'd3; tick();
        check(rx_dma_req, 1'b0, "R9 level 3");
        rx_level = 4'd4; tick();
        check(rx_dma_req, 1'b1, "R9 level 4");
        rx_dma_en = 0; tick();
        check(rx_dma_req, 1'b0, "R10 rx disabled");
    endtask

    task automatic t_debug();
        tx_dma_en = 1; tx_burst = 0; tx_level = 4'd0;
        rx_dma_en = 1; rx_burst = 1; rx_level = 4'd4;
        core_debug = 1; tx_dbg_halt_en = 1; rx_dbg_halt_en = 0; tick();
        check(tx_dma_req, 1'b0, "R11 tx halted in debug");
        check(rx_dma_req, 1'b1, "R11 rx unaffected");
        rx_dbg_halt_en = 1; tick();
        check(rx_dma_req, 1'b0, "R11 rx halted in debug");
        core_debug = 0; tick();
        check(tx_dma_req, 1'b1, "R11 tx resumes");
        tx_dbg_halt_en = 0; rx_dbg_halt_en = 0;
    endtask

    task automatic t_flush();
        tick();
        check(tx_dma_req, 1'b1, "R12 tx request before flush");
        tx_flush = 1; #1;
        check(tx_dma_req, 1'b0, "R12 tx dropped same cycle");
        check(rx_dma_req, 1'b1, "R12 rx unaffected by tx flush");
        @(negedge clk); tx_flush = 0; #1;
        check(tx_dma_req, 1'b0, "R12 tx low following cycle");
        @(negedge clk);
        check(tx_dma_req, 1'b1, "R12 tx returns");
        rx_flush = 1; #1;
        check(rx_dma_req, 1'b0, "R12 rx dropped same cycle");
        @(negedge clk); rx_flush = 0;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1;
        tick();
        t_wmark();
        t_sticky();
        t_irq();
        t_tx_dma();
        t_rx_dma();
        t_debug();
        t_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule